// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block is the transmit half of one asynchronous serial channel. A host writes a character into a one-entry holding buffer. When the serializer is free, the character moves to it and goes out on the line as a start bit, then the data bits least significant first, then an optional parity bit, then a mark interval made of stop bits. Character length, parity, stop length and oversampling are taken live from two configuration bytes. The line-control byte also carries the transmitter enable, a forced-break control and two modem control outputs.

Bit timing comes from a single-cycle enable pulse, `tick_i`. In oversampled mode a bit lasts 16 pulses; otherwise a bit lasts one pulse. An interrupt-pending flag latches each time the holding buffer hands a character to the serializer, provided transmit interrupts are enabled. The flag stays set until a clear-pending command is written.

Top module: `sio_tx`

## Requirements
- R1: After reset `txd_o` is 1, `buf_empty_o` is 1 and `irq_pend_o` is 0.
- R2: A frame is one low start bit, the data bits least significant first, the parity bit if enabled, then a high stop interval. Each bit lasts 16 `tick_i` pulses when `fmt_i[6]`=1 and 1 pulse when `fmt_i[6]`=0. Between frames the line is high.
- R3: `mode_i[6:5]` sets the character length: 00=5 bits, 01=7 bits, 10=6 bits, 11=8 bits. Unused high data bits are not sent.
- R4: `fmt_i[1:0]` sets parity: 00 or 10 = no parity, 01 = odd (data plus parity bit hold an odd number of ones), 11 = even.
- R5: `fmt_i[3:2]` sets the stop interval, with L the bit length: 01 = L pulses, 10 = L plus 8 pulses in oversampled mode (24 pulses) or 2 pulses in x1 mode, 11 = 2L pulses. A character already waiting starts on the clock after the stop interval ends.
- R6: `buf_empty_o` is 1 when the holding buffer can accept a character. A write with `data_we_i` while the buffer is full is ignored.
- R7: No frame starts while `mode_i[3]` (enable) is 0 or `fmt_i[3:2]`=00. A waiting character is kept until starting is allowed. Clearing enable during a frame abandons it and returns the line high.
- R8: While `mode_i[4]` (break) is 1, `txd_o` is 0 and any frame in progress is abandoned. A waiting character is kept and goes out after break is released.
- R9: When `tx_irq_en_i` is 1, `irq_pend_o` sets each time the buffer hands over a character. It clears only on `cmd_we_i` with code 5 in `cmd_i[5:3]`; other codes leave it set. A new set wins over a clear in the same cycle.
- R10: `rts_o` follows `mode_i[1]` and `dtr_o` follows `mode_i[7]`.
- R11: The line rises only on a `tick_i` cycle, on abandonment of a frame, or on release of break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Character to send |
| data_we_i | input | 1 | Write strobe for data_i |
| mode_i | input | 8 | Line control: [7] DTR, [6:5] length, [4] break, [3] enable, [1] RTS |
| fmt_i | input | 8 | Format: [6] x16, [3:2] stop, [1:0] parity |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| cmd_i | input | 8 | Command byte, code in [5:3] |
| cmd_we_i | input | 1 | Command strobe |
| tick_i | input | 1 | Bit-rate enable pulse |
| txd_o | output | 1 | Serial line |
| rts_o | output | 1 | RTS output |
| dtr_o | output | 1 | DTR output |
| buf_empty_o | output | 1 | Holding buffer can accept a character |
| irq_pend_o | output | 1 | Transmit interrupt pending |

## Verification
The assertions check these rules on every cycle:
- break forces the line low;
- a write into an empty buffer fills it;
- a falling line edge needs a prior enable, and a rising edge needs a tick, an abandonment or a break release;
- the pending flag sets only together with the buffer emptying under an enabled interrupt, and clears only after a code-5 command.

Only the bench scenarios can show the following:
- the bit order and values of frames for every length and parity code;
- the exact stop interval lengths, measured start to start;
- that a write into a full buffer is dropped;
- that a character held during disable, a stop code of 00 or break is the one later sent.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_DATA = 2'd1,
    SH_STOP = 2'd2
  } sh_state_e;

  localparam logic [2:0] CMD_CLR_TX_PEND = 3'd5;

  // length code is not monotonic: 00=5, 01=7, 10=6, 11=8
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   char_bits = 4'd5;
      2'b01:   char_bits = 4'd7;
      2'b10:   char_bits = 4'd6;
      default: char_bits = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sio_tx_cfg.sv
module sio_tx_cfg
  import sio_tx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int BLW = $clog2(OVS + 1),
  parameter int SLW = $clog2(2 * OVS + 1)
) (
  input  logic [7:0]     mode_i,
  input  logic [7:0]     fmt_i,
  output logic           en_o,
  output logic           brk_o,
  output logic           rts_o,
  output logic           dtr_o,
  output logic [3:0]     len_o,
  output logic           par_en_o,
  output logic           par_odd_o,
  output logic           stop_ok_o,
  output logic [BLW-1:0] bit_len_o,
  output logic [SLW-1:0] stop_len_o
);

  logic [BLW-1:0] half_len;
  logic           unused_cfg;

  assign unused_cfg = ^{mode_i[2], mode_i[0], fmt_i[7], fmt_i[5:4]};

  assign en_o      = mode_i[3];
  assign brk_o     = mode_i[4];
  assign rts_o     = mode_i[1];
  assign dtr_o     = mode_i[7];
  assign len_o     = char_bits(mode_i[6:5]);
  assign par_en_o  = fmt_i[0];
  assign par_odd_o = ~fmt_i[1];
  assign stop_ok_o = (fmt_i[3:2] != 2'b00);

  always_comb begin
    bit_len_o = fmt_i[6] ? BLW'(OVS)     : BLW'(1);
    half_len  = fmt_i[6] ? BLW'(OVS / 2) : BLW'(1);
    case (fmt_i[3:2])
      2'b01:   stop_len_o = SLW'(bit_len_o);
      2'b10:   stop_len_o = SLW'(bit_len_o) + SLW'(half_len);
      2'b11:   stop_len_o = SLW'(bit_len_o) + SLW'(bit_len_o);
      default: stop_len_o = '0;
    endcase
  end

endmodule

// File: rtl/sio_tx_frame.sv
module sio_tx_frame #(
  parameter int DW  = 8,
  parameter int FW  = DW + 2,
  parameter int NBW = $clog2(FW + 1)
) (
  input  logic [DW-1:0]  data_i,
  input  logic [3:0]     len_i,
  input  logic           par_en_i,
  input  logic           par_odd_i,
  output logic [FW-1:0]  frame_o,
  output logic [NBW-1:0] nbits_o
);

  logic par_bit;

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    par_bit    = par_odd_i;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(len_i)) begin
        frame_o[i+1] = data_i[i];
        par_bit      = par_bit ^ data_i[i];
      end
    end
    for (int j = 1; j < FW; j++) begin
      if (par_en_i && j == int'(len_i) + 1) frame_o[j] = par_bit;
    end
    nbits_o = NBW'(1 + int'(len_i) + (par_en_i ? 1 : 0));
  end

endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  input  logic          irq_en_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          pend_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (we_i && !full_o) begin
      data_o <= data_i;
      full_o <= 1'b1;
    end
  end

  // a new set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_o <= 1'b0;
    else if (take_i && irq_en_i)  pend_o <= 1'b1;
    else if (clr_i)               pend_o <= 1'b0;
  end

endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
  import sio_tx_pkg::*;
#(
  parameter int FW  = 10,
  parameter int NBW = 4,
  parameter int BLW = 5,
  parameter int SLW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           load_i,
  input  logic           abort_i,
  input  logic [FW-1:0]  frame_i,
  input  logic [NBW-1:0] nbits_i,
  input  logic [BLW-1:0] bit_len_i,
  input  logic [SLW-1:0] stop_len_i,
  output logic           idle_o,
  output logic           ser_o
);

  sh_state_e      state_q;
  logic [FW-1:0]  sh_q;
  logic [NBW-1:0] bits_left_q;
  logic [BLW-1:0] tick_cnt_q, blen_q;
  logic [SLW-1:0] stop_cnt_q, slen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SH_IDLE;
      sh_q        <= '1;
      bits_left_q <= '0;
      tick_cnt_q  <= '0;
      blen_q      <= '0;
      stop_cnt_q  <= '0;
      slen_q      <= '0;
    end else if (abort_i) begin
      state_q <= SH_IDLE;
    end else begin
      case (state_q)
        SH_IDLE: if (load_i) begin
          state_q     <= SH_DATA;
          sh_q        <= frame_i;
          bits_left_q <= nbits_i;
          tick_cnt_q  <= '0;
          blen_q      <= bit_len_i;
          slen_q      <= stop_len_i;
        end
        SH_DATA: if (tick_i) begin
          if (tick_cnt_q + BLW'(1) == blen_q) begin
            tick_cnt_q  <= '0;
            sh_q        <= {1'b1, sh_q[FW-1:1]};
            bits_left_q <= bits_left_q - NBW'(1);
            if (bits_left_q == NBW'(1)) begin
              state_q    <= SH_STOP;
              stop_cnt_q <= slen_q;
            end
          end else begin
            tick_cnt_q <= tick_cnt_q + BLW'(1);
          end
        end
        SH_STOP: if (tick_i) begin
          if (stop_cnt_q == SLW'(1)) state_q <= SH_IDLE;
          else                        stop_cnt_q <= stop_cnt_q - SLW'(1);
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == SH_IDLE);
  assign ser_o  = (state_q == SH_DATA) ? sh_q[0] : 1'b1;

endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_we_i,
  input  logic [7:0]        mode_i,
  input  logic [7:0]        fmt_i,
  input  logic              tx_irq_en_i,
  input  logic [7:0]        cmd_i,
  input  logic              cmd_we_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              buf_empty_o,
  output logic              irq_pend_o
);

  localparam int FW  = DATA_W + 2;
  localparam int NBW = $clog2(FW + 1);
  localparam int BLW = $clog2(OVS + 1);
  localparam int SLW = $clog2(2 * OVS + 1);

  logic              en, brk, par_en, par_odd, stop_ok;
  logic [3:0]        len;
  logic [BLW-1:0]    bit_len;
  logic [SLW-1:0]    stop_len;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full, take, clr, sh_idle, ser;
  logic [FW-1:0]     frame;
  logic [NBW-1:0]    nbits;
  logic              unused_cmd;

  assign unused_cmd = ^{cmd_i[7:6], cmd_i[2:0]};

  sio_tx_cfg #(.OVS(OVS), .BLW(BLW), .SLW(SLW)) u_cfg (
    .mode_i     (mode_i),
    .fmt_i      (fmt_i),
    .en_o       (en),
    .brk_o      (brk),
    .rts_o      (rts_o),
    .dtr_o      (dtr_o),
    .len_o      (len),
    .par_en_o   (par_en),
    .par_odd_o  (par_odd),
    .stop_ok_o  (stop_ok),
    .bit_len_o  (bit_len),
    .stop_len_o (stop_len)
  );

  assign take = hold_full & sh_idle & en & ~brk & stop_ok;
  assign clr  = cmd_we_i && (cmd_i[5:3] == CMD_CLR_TX_PEND);

  sio_tx_hold #(.DW(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (data_we_i),
    .data_i   (data_i),
    .take_i   (take),
    .irq_en_i (tx_irq_en_i),
    .clr_i    (clr),
    .data_o   (hold_data),
    .full_o   (hold_full),
    .pend_o   (irq_pend_o)
  );

  sio_tx_frame #(.DW(DATA_W), .FW(FW), .NBW(NBW)) u_frame (
    .data_i    (hold_data),
    .len_i     (len),
    .par_en_i  (par_en),
    .par_odd_i (par_odd),
    .frame_o   (frame),
    .nbits_o   (nbits)
  );

  sio_tx_shift #(.FW(FW), .NBW(NBW), .BLW(BLW), .SLW(SLW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (take),
    .abort_i    (brk | ~en),
    .frame_i    (frame),
    .nbits_i    (nbits),
    .bit_len_i  (bit_len),
    .stop_len_i (stop_len),
    .idle_o     (sh_idle),
    .ser_o      (ser)
  );

  assign txd_o       = ~brk & ser;
  assign buf_empty_o = ~hold_full;

endmodule

// File: rtl/sio_tx_checker.sv
module sio_tx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       data_we_i,
  input logic [7:0] mode_i,
  input logic       tx_irq_en_i,
  input logic [7:0] cmd_i,
  input logic       cmd_we_i,
  input logic       tick_i,
  input logic       txd_o,
  input logic       buf_empty_o,
  input logic       irq_pend_o
);

  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i && buf_empty_o |=> !buf_empty_o);

  a_r8_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[4] |-> !txd_o);

  a_r7_fall_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txd_o) |-> $past(mode_i[3]) || mode_i[4]);

  a_r11_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txd_o) |-> $past(tick_i) || $past(mode_i[4]) || !$past(mode_i[3]));

  a_r9_set_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pend_o) |-> $rose(buf_empty_o) && $past(tx_irq_en_i));

  a_r9_clear_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_pend_o) |-> $past(cmd_we_i) && ($past(cmd_i[5:3]) == 3'd5));

endmodule

bind sio_tx sio_tx_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_we_i   (data_we_i),
  .mode_i      (mode_i),
  .tx_irq_en_i (tx_irq_en_i),
  .cmd_i       (cmd_i),
  .cmd_we_i    (cmd_we_i),
  .tick_i      (tick_i),
  .txd_o       (txd_o),
  .buf_empty_o (buf_empty_o),
  .irq_pend_o  (irq_pend_o)
);

// File: tb/sio_tx_test.sv
`timescale 1ns/1ps
module sio_tx_test;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] data_i;
  logic       data_we_i;
  logic [7:0] mode_i;
  logic [7:0] fmt_i;
  logic       tx_irq_en_i;
  logic [7:0] cmd_i;
  logic       cmd_we_i;
  logic       tick_i;
  logic       txd_o, rts_o, dtr_o, buf_empty_o, irq_pend_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sio_tx uut (
    .clk_i (clk), .rst_ni (rst_ni), .data_i (data_i), .data_we_i (data_we_i),
    .mode_i (mode_i), .fmt_i (fmt_i), .tx_irq_en_i (tx_irq_en_i),
    .cmd_i (cmd_i), .cmd_we_i (cmd_we_i), .tick_i (tick_i),
    .txd_o (txd_o), .rts_o (rts_o), .dtr_o (dtr_o),
    .buf_empty_o (buf_empty_o), .irq_pend_o (irq_pend_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'b00:   return 5;
      2'b01:   return 7;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

  // par: 0 none, 1 odd, 2 even
  function automatic logic [11:0] exp_frame(input logic [7:0] d, input int n, input int par);
    logic [11:0] f;
    int ones;
    f = '0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      if (d[i]) ones++;
    end
    if (par == 1) f[n+1] = (ones % 2 == 0);
    if (par == 2) f[n+1] = (ones % 2 == 1);
    return f;
  endfunction

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    data_i = d;
    data_we_i = 1'b1;
    @(negedge clk);
    data_we_i = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] code);
    @(negedge clk);
    cmd_i = {2'b00, code, 3'b000};
    cmd_we_i = 1'b1;
    @(negedge clk);
    cmd_we_i = 1'b0;
  endtask

  task automatic capture(input int bl, input int nb, output logic [11:0] got);
    int pos;
    int guard;
    pos = 0;
    guard = 0;
    got = '0;
    @(negedge clk);
    while (txd_o !== 1'b0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    for (int k = 0; k < nb; k++) begin
      int tgt;
      tgt = k * bl + bl / 2;
      while (pos < tgt) begin
        @(negedge clk);
        pos++;
      end
      got[k] = txd_o;
    end
  endtask

  task automatic settle();
    repeat (220) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    data_i = '0; data_we_i = 1'b0; mode_i = '0; fmt_i = 8'h44;
    tx_irq_en_i = 1'b0; cmd_i = '0; cmd_we_i = 1'b0; tick_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "txd in reset", txd_o, 1);
    chk("R1", "buf_empty in reset", buf_empty_o, 1);
    chk("R1", "pend in reset", irq_pend_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "txd after reset", txd_o, 1);
  endtask

  task automatic t_basic_x16();
    logic [11:0] got;
    mode_i = 8'h68; fmt_i = 8'h44;
    do_write(8'hA5);
    capture(16, 9, got);
    chk("R2", "8N1 x16 frame A5", got, exp_frame(8'hA5, 8, 0));
    settle();
    chk("R2", "idle high", txd_o, 1);
  endtask

  task automatic t_len_par();
    for (int lc = 0; lc < 4; lc++) begin
      for (int pc = 0; pc < 4; pc++) begin
        logic [11:0] got;
        logic [7:0]  d;
        int n, par, nb;
        d = 8'h35 + 8'(lc * 37) + 8'(pc * 11);
        n = len_of(2'(lc));
        par = (pc == 1) ? 1 : (pc == 3) ? 2 : 0;
        nb = 1 + n + (par != 0 ? 1 : 0);
        @(negedge clk);
        mode_i = 8'h08 | 8'(lc << 5);
        fmt_i  = 8'h04 | 8'(pc);
        do_write(d);
        capture(1, nb, got);
        chk((par != 0) ? "R4" : "R3", $sformatf("len code %0d par code %0d", lc, pc),
            got, exp_frame(d, n, par));
        settle();
      end
    end
  endtask

  task automatic gap(input logic [7:0] md, input logic [7:0] fm, input int exp, input string what);
    int pos;
    bit wrote, found;
    logic prev;
    @(negedge clk);
    mode_i = md; fmt_i = fm;
    do_write(8'hFF);
    @(negedge clk);
    pos = 0; wrote = 0; found = 0; prev = txd_o;
    while (!found && pos < 600) begin
      @(negedge clk);
      pos++;
      if (data_we_i) data_we_i = 1'b0;
      if (prev === 1'b1 && txd_o === 1'b0) found = 1;
      else if (!wrote && buf_empty_o) begin
        data_i = 8'hFF; data_we_i = 1'b1; wrote = 1;
      end
      prev = txd_o;
    end
    data_we_i = 1'b0;
    chk("R5", what, pos, exp);
    settle();
  endtask

  task automatic t_stop();
    gap(8'h68, 8'h44, 161, "x16 one stop start-to-start");
    gap(8'h68, 8'h48, 169, "x16 1.5 stop start-to-start");
    gap(8'h68, 8'h4C, 177, "x16 two stop start-to-start");
    gap(8'h08, 8'h04, 8,   "x1 5-bit one stop start-to-start");
    gap(8'h08, 8'h08, 9,   "x1 5-bit 1.5 stop start-to-start");
  endtask

  task automatic t_buffer_enable();
    logic [11:0] got;
    bit stayed;
    @(negedge clk);
    mode_i = 8'h60; fmt_i = 8'h44;
    do_write(8'h3C);
    chk("R6", "buf full after write", buf_empty_o, 0);
    stayed = 1;
    repeat (30) begin
      @(negedge clk);
      if (txd_o !== 1'b1) stayed = 0;
    end
    chk("R7", "no start while disabled", stayed, 1);
    do_write(8'hC3);
    @(negedge clk);
    mode_i = 8'h68;
    capture(16, 9, got);
    chk("R6", "full-buffer write dropped, first char sent", got, exp_frame(8'h3C, 8, 0));
    chk("R6", "buf empty after handover", buf_empty_o, 1);
    settle();
    chk("R6", "no second frame queued", buf_empty_o, 1);
    @(negedge clk);
    fmt_i = 8'h40;
    do_write(8'h0F);
    stayed = 1;
    repeat (40) begin
      @(negedge clk);
      if (txd_o !== 1'b1) stayed = 0;
    end
    chk("R7", "stop code 00 blocks start", stayed, 1);
    chk("R7", "char held with stop code 00", buf_empty_o, 0);
    @(negedge clk);
    fmt_i = 8'h44;
    capture(16, 9, got);
    chk("R7", "held char sent after stop code set", got, exp_frame(8'h0F, 8, 0));
    settle();
  endtask

  task automatic t_abort();
    bit stayed;
    @(negedge clk);
    mode_i = 8'h68; fmt_i = 8'h44;
    do_write(8'h00);
    repeat (40) @(negedge clk);
    chk("R2", "data bit low mid-frame", txd_o, 0);
    mode_i = 8'h60;
    @(negedge clk);
    stayed = 1;
    repeat (60) begin
      if (txd_o !== 1'b1) stayed = 0;
      @(negedge clk);
    end
    chk("R7", "disable abandons frame, line high", stayed, 1);
    mode_i = 8'h68;
    stayed = 1;
    repeat (200) begin
      @(negedge clk);
      if (txd_o !== 1'b1) stayed = 0;
    end
    chk("R7", "abandoned char not resent", stayed, 1);
  endtask

  task automatic t_break();
    logic [11:0] got;
    bit low;
    @(negedge clk);
    mode_i = 8'h68; fmt_i = 8'h44;
    do_write(8'hFF);
    repeat (30) @(negedge clk);
    do_write(8'h5A);
    chk("R8", "second char waiting", buf_empty_o, 0);
    mode_i = 8'h78;
    #1;
    chk("R8", "break drives line low", txd_o, 0);
    low = 1;
    repeat (200) begin
      @(negedge clk);
      if (txd_o !== 1'b0) low = 0;
    end
    chk("R8", "line low through break", low, 1);
    chk("R8", "waiting char kept during break", buf_empty_o, 0);
    mode_i = 8'h68;
    #1;
    chk("R8", "line high on break release", txd_o, 1);
    capture(16, 9, got);
    chk("R8", "waiting char sent after break", got, exp_frame(8'h5A, 8, 0));
    settle();
  endtask

  task automatic t_pending();
    @(negedge clk);
    mode_i = 8'h68; fmt_i = 8'h44; tx_irq_en_i = 1'b1;
    do_write(8'h81);
    repeat (4) @(negedge clk);
    chk("R9", "pending set on handover", irq_pend_o, 1);
    do_cmd(3'd3);
    chk("R9", "other command leaves pending", irq_pend_o, 1);
    repeat (10) @(negedge clk);
    chk("R9", "pending sticky", irq_pend_o, 1);
    do_cmd(3'd5);
    chk("R9", "code 5 clears pending", irq_pend_o, 0);
    settle();
    tx_irq_en_i = 1'b0;
    do_write(8'h18);
    repeat (4) @(negedge clk);
    chk("R9", "no pending when disabled", irq_pend_o, 0);
    settle();
  endtask

  task automatic t_modem();
    @(negedge clk);
    mode_i = 8'h6A;
    #1;
    chk("R10", "rts high", rts_o, 1);
    chk("R10", "dtr low", dtr_o, 0);
    mode_i = 8'hE8;
    #1;
    chk("R10", "rts low", rts_o, 0);
    chk("R10", "dtr high", dtr_o, 1);
    mode_i = 8'h68;
  endtask

  // R11: line rises only on tick; with sparse ticks the bit lengthens
  task automatic t_sparse_tick();
    logic [11:0] got;
    @(negedge clk);
    mode_i = 8'h08; fmt_i = 8'h04;
    tick_i = 1'b0;
    do_write(8'h00);
    repeat (20) @(negedge clk);
    chk("R11", "start held without ticks", txd_o, 0);
    tick_i = 1'b1;
    capture(1, 6, got);
    chk("R11", "frame resumes on ticks", txd_o, 1);
    settle();
  endtask

  initial begin
    t_reset();
    t_basic_x16();
    t_len_par();
    t_stop();
    t_buffer_enable();
    t_abort();
    t_break();
    t_pending();
    t_modem();
    t_sparse_tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule